// File: doc/BRIEF.md
# Paged Program Counter with Four-Phase Sequencer

This block holds the program counter of a processor that fetches two-byte instruction words from byte-addressed program memory. The counter is 21 bits wide. Bit 0 always reads zero, so sequential execution moves the counter forward by two. A built-in four-state sequencer splits each instruction cycle into four clock phases, Q1 to Q4. On the edge that ends Q1, the current counter value is captured as the fetch address and the counter advances. On the edge that ends Q4, the unit applies whatever change the execute stage requests.

Software sees only the low byte of the counter. The bits above it are reached through two holding registers: a middle latch for bits 15:8 and an upper latch for bits 20:16. A write to the low byte moves both latches into the upper counter bits in the same step. A read of the low byte copies the upper counter bits back into the latches. A direct branch or call loads a full target and ignores the latches.

Any change of the counter raises a flush flag for the whole of the next instruction cycle. During that cycle the already-fetched word executes as a no-op, so a taken change costs two instruction cycles.

Sequencer states: `PH_Q1`, `PH_Q2`, `PH_Q3` and `PH_Q4`. The only transitions are Q1→Q2, Q2→Q3, Q3→Q4 and Q4→Q1. Reset enters `PH_Q1`.

Top module: `pc_unit`

## Requirements
- R1: `phase_o` is one-hot with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. It steps Q1→Q2→Q3→Q4→Q1 on every clock and shows Q1 during and straight after reset.
- R2: During reset, the fetch address, the counter (seen on `pcl_rdata_o`), both latches and `flush_o` are all zero.
- R3: On the edge that ends Q1, `fetch_addr_o` takes the counter value and the counter advances by 2, wrapping modulo 2^21.
- R4: Bit 0 of the counter is always zero. Bit 0 of the branch target and of the low-byte write data is discarded.
- R5: A low-byte write loads the counter with {upper latch, middle latch, write data}. The latch values used are those the latches hold after the same edge.
- R6: A low-byte read copies counter bits 15:8 into the middle latch and bits 20:16 into the upper latch. `pcl_rdata_o` shows counter bits 7:0 at all times.
- R7: A latch write loads the middle latch from `lat_wdata_i` and the upper latch from `lat_wdata_i[4:0]`. If a low-byte read occurs on the same edge, the copy from the read wins.
- R8: A direct branch loads the whole target, ignoring the latches. It takes priority over a low-byte write on the same edge.
- R9: All requests (low-byte write/read, latch writes, branch) are sampled only on the edge that ends Q4. Strobes present only in Q1–Q3 change nothing.
- R10: `flush_o` is high for exactly the instruction cycle after a branch or low-byte write. It is low after any other cycle.
- R11: A low-byte write combined with a low-byte read on the same edge keeps counter bits 20:8 unchanged. The latches are refreshed and then used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, one phase per period |
| rst_n | input | 1 | Asynchronous reset, active low |
| pcl_wr_i | input | 1 | Low-byte write request |
| pcl_rd_i | input | 1 | Low-byte read request (refreshes latches) |
| pcl_wdata_i | input | 8 | Low-byte write data |
| lat_mid_wr_i | input | 1 | Middle latch write request |
| lat_up_wr_i | input | 1 | Upper latch write request |
| lat_wdata_i | input | 8 | Latch write data |
| br_en_i | input | 1 | Direct branch/call request |
| br_target_i | input | PC_W | Branch target address |
| phase_o | output | 4 | One-hot phase, bit 0 = Q1 |
| fetch_addr_o | output | PC_W | Address of the word fetched this cycle |
| flush_o | output | 1 | Current cycle executes as no-op |
| pcl_rdata_o | output | 8 | Counter bits 7:0 |
| lat_mid_o | output | 8 | Middle latch contents |
| lat_up_o | output | PC_W-16 | Upper latch contents |

## Verification
The bench builds the unit with its default 21-bit width, which gives a 5-bit upper latch. With this width, a branch to the top even address brings the modulo wrap of the sequential increment within reach. It also lets a shared 8-bit latch data bus show the truncation into the upper latch. Directed instruction cycles cover the priority collisions: branch against write, read against latch write, and read with write. A strobe held only outside Q4 checks that it is ignored. An LFSR-driven run then mixes all requests while the reference model is compared on every clock.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    localparam int NUM_PHASES = 4;
    localparam int BYTE_W     = 8;
    localparam int LOW_W      = 8;
    localparam int MID_W      = 8;

endpackage

// File: rtl/pc_phase_fsm.sv
module pc_phase_fsm
    import pc_unit_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_PHASES-1:0] phase_o,
    output logic                  step_o,
    output logic                  commit_o
);

    phase_e st_q;
    phase_e st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PH_Q1;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_Q1: st_d = PH_Q2;
            PH_Q2: st_d = PH_Q3;
            PH_Q3: st_d = PH_Q4;
            PH_Q4: st_d = PH_Q1;
            default: st_d = PH_Q1;
        endcase
    end

    // outputs
    always_comb begin
        phase_o  = '0;
        step_o   = 1'b0;
        commit_o = 1'b0;
        unique case (st_q)
            PH_Q1: begin
                phase_o[0] = 1'b1;
                step_o     = 1'b1;
            end
            PH_Q2: phase_o[1] = 1'b1;
            PH_Q3: phase_o[2] = 1'b1;
            PH_Q4: begin
                phase_o[3] = 1'b1;
                commit_o   = 1'b1;
            end
            default: phase_o = '0;
        endcase
    end

endmodule

// File: rtl/pc_latch_bank.sv
module pc_latch_bank
    import pc_unit_pkg::*;
#(
    parameter int UP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              mid_wr_i,
    input  logic              up_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              snap_i,
    input  logic [MID_W-1:0]  pc_mid_i,
    input  logic [UP_W-1:0]   pc_up_i,
    output logic [MID_W-1:0]  mid_q_o,
    output logic [UP_W-1:0]   up_q_o,
    output logic [MID_W-1:0]  mid_nx_o,
    output logic [UP_W-1:0]   up_nx_o
);

    logic [MID_W-1:0] mid_q;
    logic [UP_W-1:0]  up_q;

    // value each latch takes on a commit edge; a snapshot beats a direct write
    always_comb begin
        mid_nx_o = mid_q;
        up_nx_o  = up_q;
        if (mid_wr_i) begin
            mid_nx_o = wdata_i;
        end
        if (up_wr_i) begin
            up_nx_o = wdata_i[UP_W-1:0];
        end
        if (snap_i) begin
            mid_nx_o = pc_mid_i;
            up_nx_o  = pc_up_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_q <= '0;
            up_q  <= '0;
        end else if (commit_i) begin
            mid_q <= mid_nx_o;
            up_q  <= up_nx_o;
        end
    end

    assign mid_q_o = mid_q;
    assign up_q_o  = up_q;

endmodule

// File: rtl/pc_counter.sv
module pc_counter
    import pc_unit_pkg::*;
#(
    parameter int PC_W = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_i,
    input  logic                 commit_i,
    input  logic                 br_en_i,
    input  logic [PC_W-1:0]      br_target_i,
    input  logic                 pcl_wr_i,
    input  logic [LOW_W-1:0]     pcl_wdata_i,
    input  logic [MID_W-1:0]     lat_mid_nx_i,
    input  logic [PC_W-17:0]     lat_up_nx_i,
    output logic [PC_W-1:0]      pc_o,
    output logic [PC_W-1:0]      fetch_o,
    output logic                 flush_o
);

    localparam logic [PC_W-1:0] WORD_STEP = PC_W'(2);
    localparam logic [PC_W-1:0] EVEN_MASK = ~PC_W'(1);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] fetch_q;
    logic            flush_q;
    logic [PC_W-1:0] load_val;
    logic            load_en;

    // direct branch wins over a computed jump through the latches
    always_comb begin
        load_en  = br_en_i | pcl_wr_i;
        load_val = pc_q;
        if (br_en_i) begin
            load_val = br_target_i & EVEN_MASK;
        end else if (pcl_wr_i) begin
            load_val = {lat_up_nx_i, lat_mid_nx_i, pcl_wdata_i & 8'hFE};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            fetch_q <= '0;
            flush_q <= 1'b0;
        end else begin
            if (step_i) begin
                fetch_q <= pc_q;
                pc_q    <= pc_q + WORD_STEP;
            end
            if (commit_i) begin
                flush_q <= load_en;
                if (load_en) begin
                    pc_q <= load_val;
                end
            end
        end
    end

    assign pc_o    = pc_q;
    assign fetch_o = fetch_q;
    assign flush_o = flush_q;

endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import pc_unit_pkg::*;
#(
    parameter int PC_W = 21,
    localparam int UP_W = PC_W - 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pcl_wr_i,
    input  logic                  pcl_rd_i,
    input  logic [7:0]            pcl_wdata_i,
    input  logic                  lat_mid_wr_i,
    input  logic                  lat_up_wr_i,
    input  logic [7:0]            lat_wdata_i,
    input  logic                  br_en_i,
    input  logic [PC_W-1:0]       br_target_i,
    output logic [3:0]            phase_o,
    output logic [PC_W-1:0]       fetch_addr_o,
    output logic                  flush_o,
    output logic [7:0]            pcl_rdata_o,
    output logic [7:0]            lat_mid_o,
    output logic [UP_W-1:0]       lat_up_o
);

    logic            step;
    logic            commit;
    logic [PC_W-1:0] pc;
    logic [MID_W-1:0] mid_nx;
    logic [UP_W-1:0]  up_nx;

    pc_phase_fsm u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_o  (phase_o),
        .step_o   (step),
        .commit_o (commit)
    );

    pc_latch_bank #(
        .UP_W (UP_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .mid_wr_i (lat_mid_wr_i),
        .up_wr_i  (lat_up_wr_i),
        .wdata_i  (lat_wdata_i),
        .snap_i   (pcl_rd_i),
        .pc_mid_i (pc[15:8]),
        .pc_up_i  (pc[PC_W-1:16]),
        .mid_q_o  (lat_mid_o),
        .up_q_o   (lat_up_o),
        .mid_nx_o (mid_nx),
        .up_nx_o  (up_nx)
    );

    pc_counter #(
        .PC_W (PC_W)
    ) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step),
        .commit_i     (commit),
        .br_en_i      (br_en_i),
        .br_target_i  (br_target_i),
        .pcl_wr_i     (pcl_wr_i),
        .pcl_wdata_i  (pcl_wdata_i),
        .lat_mid_nx_i (mid_nx),
        .lat_up_nx_i  (up_nx),
        .pc_o         (pc),
        .fetch_o      (fetch_addr_o),
        .flush_o      (flush_o)
    );

    assign pcl_rdata_o = pc[7:0];

endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk #(
    parameter int UP_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      phase_o,
    input logic [7:0]      fetch_lo,
    input logic            flush_o,
    input logic [7:0]      pcl_rdata_o,
    input logic [7:0]      lat_mid_o,
    input logic [UP_W-1:0] lat_up_o,
    input logic            pcl_wr_i,
    input logic [7:0]      pcl_wdata_i,
    input logic            br_en_i,
    input logic [7:0]      br_tgt_lo
);

    p_phase_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_o) == 1);

    p_phase_q1_q2_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o[0] |=> phase_o[1]);

    p_phase_q4_q1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o[3] |=> phase_o[0]);

    p_lsb_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_lo[0] == 1'b0) && (pcl_rdata_o[0] == 1'b0));

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o[0] |=> (fetch_lo == $past(pcl_rdata_o))
                    && (pcl_rdata_o == $past(pcl_rdata_o) + 8'd2));

    p_quiet_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_o[3] |=> $stable(lat_mid_o) && $stable(lat_up_o) && $stable(flush_o));

    p_branch_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o[3] && br_en_i) |=> flush_o && (pcl_rdata_o == ($past(br_tgt_lo) & 8'hFE)));

    p_write_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o[3] && pcl_wr_i && !br_en_i) |=> pcl_rdata_o == ($past(pcl_wdata_i) & 8'hFE));

    p_no_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o[3] && !br_en_i && !pcl_wr_i) |=> !flush_o);

endmodule

bind pc_unit pc_unit_chk #(.UP_W(UP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_o     (phase_o),
    .fetch_lo    (fetch_addr_o[7:0]),
    .flush_o     (flush_o),
    .pcl_rdata_o (pcl_rdata_o),
    .lat_mid_o   (lat_mid_o),
    .lat_up_o    (lat_up_o),
    .pcl_wr_i    (pcl_wr_i),
    .pcl_wdata_i (pcl_wdata_i),
    .br_en_i     (br_en_i),
    .br_tgt_lo   (br_target_i[7:0])
);

// File: tb/pc_unit_tb.sv
module pc_unit_tb;

    localparam int PC_W = 21;
    localparam int UP_W = PC_W - 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            pcl_wr = 1'b0, pcl_rd = 1'b0, mid_wr = 1'b0, up_wr = 1'b0, br_en = 1'b0;
    logic [7:0]      pcl_wd = '0, lat_wd = '0;
    logic [PC_W-1:0] br_tgt = '0;
    logic [3:0]      phase;
    logic [PC_W-1:0] fetch;
    logic            flush;
    logic [7:0]      pcl_rd_data, lat_mid;
    logic [UP_W-1:0] lat_up;

    pc_unit u_dut (
        .clk (clk), .rst_n (rst_n),
        .pcl_wr_i (pcl_wr), .pcl_rd_i (pcl_rd), .pcl_wdata_i (pcl_wd),
        .lat_mid_wr_i (mid_wr), .lat_up_wr_i (up_wr), .lat_wdata_i (lat_wd),
        .br_en_i (br_en), .br_target_i (br_tgt),
        .phase_o (phase), .fetch_addr_o (fetch), .flush_o (flush),
        .pcl_rdata_o (pcl_rd_data), .lat_mid_o (lat_mid), .lat_up_o (lat_up)
    );

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int              m_ph;
    logic [PC_W-1:0] m_pc, m_fetch;
    logic [7:0]      m_mid;
    logic [UP_W-1:0] m_up;
    logic            m_flush;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pc = '0; m_fetch = '0; m_mid = '0; m_up = '0; m_flush = 1'b0;
        end else begin
            if (m_ph == 0) begin
                m_fetch = m_pc;
                m_pc    = m_pc + 2;
            end else if (m_ph == 3) begin
                logic [7:0]      nm;
                logic [UP_W-1:0] nu;
                nm = m_mid; nu = m_up;
                if (mid_wr) nm = lat_wd;
                if (up_wr)  nu = lat_wd[UP_W-1:0];
                if (pcl_rd) begin nm = m_pc[15:8]; nu = m_pc[PC_W-1:16]; end
                if (br_en)       m_pc = br_tgt & ~PC_W'(1);
                else if (pcl_wr) m_pc = {nu, nm, pcl_wd & 8'hFE};
                m_flush = br_en | pcl_wr;
                m_mid = nm; m_up = nu;
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    always @(negedge clk) begin
        if (rst_n && running) begin
            chk("R1 phase", 32'(phase), 32'(4'b0001 << m_ph));
            chk("R3 fetch", 32'(fetch), 32'(m_fetch));
            chk("R5 pcl", 32'(pcl_rd_data), 32'(m_pc[7:0]));
            chk("R6 latch mid", 32'(lat_mid), 32'(m_mid));
            chk("R7 latch up", 32'(lat_up), 32'(m_up));
            chk("R10 flush", 32'(flush), 32'(m_flush));
        end
    end

    task automatic icyc(input logic wr, input logic [7:0] wd, input logic rd,
                        input logic mw, input logic uw, input logic [7:0] lwd,
                        input logic br, input logic [PC_W-1:0] bt);
        pcl_wr = wr; pcl_wd = wd; pcl_rd = rd; mid_wr = mw; up_wr = uw;
        lat_wd = lwd; br_en = br; br_tgt = bt;
        repeat (4) @(negedge clk);
        pcl_wr = 0; pcl_rd = 0; mid_wr = 0; up_wr = 0; br_en = 0;
    endtask

    task automatic idle();
        icyc(0, 8'h00, 0, 0, 0, 8'h00, 0, '0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1-to-R11 run actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        // R2 reset state, R1 starts in Q1
        chk("R2 fetch", 32'(fetch), 0);
        chk("R2 pcl", 32'(pcl_rd_data), 0);
        chk("R2 latches", 32'({lat_up, lat_mid}), 0);
        chk("R2 flush", 32'(flush), 0);
        chk("R1 reset phase", 32'(phase), 32'h1);
        rst_n = 1'b1;
        running = 1'b1;

        idle();
        // branch beats low-byte write; odd target bit 0 dropped
        icyc(1, 8'h77, 0, 0, 0, 8'h00, 1, 21'h12345);
        chk("R8 branch low", 32'(pcl_rd_data), 32'h44);
        chk("R4 lsb dropped", 32'(pcl_rd_data[0]), 0);
        chk("R10 flush after branch", 32'(flush), 1);
        idle();
        // low-byte read snapshots upper bits (pc 0x12348 at commit)
        icyc(0, 8'h00, 1, 0, 0, 8'h00, 0, '0);
        chk("R6 snapshot mid", 32'(lat_mid), 32'h23);
        chk("R6 snapshot up", 32'(lat_up), 32'h01);
        chk("R10 no flush on read", 32'(flush), 0);
        // latch writes and computed jump in the same cycle
        icyc(1, 8'h11, 0, 1, 1, 8'h3B, 0, '0);
        chk("R7 mid write", 32'(lat_mid), 32'h3B);
        chk("R7 up write truncated", 32'(lat_up), 32'h1B);
        chk("R5 computed jump low", 32'(pcl_rd_data), 32'h10);
        chk("R10 flush after write", 32'(flush), 1);
        // read beats latch write
        icyc(0, 8'h00, 1, 1, 0, 8'h55, 0, '0);
        chk("R7 read wins", 32'(lat_mid), 32'h3B);
        // read plus write keeps the page
        icyc(1, 8'h80, 1, 0, 0, 8'h00, 0, '0);
        idle();
        chk("R11 page kept", 32'(fetch), 32'h1B3B80);
        // strobes outside Q4 are ignored
        @(negedge clk);
        pcl_wr = 1; pcl_wd = 8'h00; br_en = 1; br_tgt = '0;
        repeat (2) @(negedge clk);
        pcl_wr = 0; br_en = 0;
        @(negedge clk);
        chk("R9 ignored outside Q4", 32'(pcl_rd_data), 32'h84);
        chk("R9 no flush", 32'(flush), 0);
        // wrap at top of address space
        icyc(0, 8'h00, 0, 0, 0, 8'h00, 1, 21'h1FFFFE);
        idle();
        chk("R3 top fetch", 32'(fetch), 32'h1FFFFE);
        chk("R3 wrapped pc", 32'(pcl_rd_data), 0);
        idle();
        chk("R3 wrapped fetch", 32'(fetch), 0);

        lf = 16'hACE1;
        for (int i = 0; i < 80; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            icyc(lf[0], lf[15:8], lf[1], lf[2], lf[3], lf[11:4],
                 lf[4] & lf[5], {lf[4:0], lf});
        end
        idle();

        summary();
        $finish;
    end

endmodule